// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a watchdog that is armed the moment the chip leaves reset. It counts down on a slow time base, a one-cycle enable arriving at 32 kHz. If software does not write a valid restart code in time, it raises a processor reset request. Restarting is keyed. Only four specific byte values written to the control register reload the count. Each of those values also picks the length of the next timeout window. Any other value written there does nothing.

A second register, the test register, does two jobs. It can switch the watchdog off for good, but only through a two-byte sequence. It can also put the block into a fast mode. In fast mode the count advances on every clock cycle and the slow enable is ignored, which makes long windows short enough to exercise. Both settings are cleared only by the block's reset.

The reset request is a one-cycle pulse. After it, the count reloads to the longest window, just as it does after reset. Window lengths are parameters given in ticks of the time base.

Top module: `kwd_timer`

## Requirements
- R1: While `rst_n` is low, `wdt_rst_req` is 0. After reset the count is loaded with the longest window (`T_LONG` ticks), so with a tick on every cycle the request pulses exactly `T_LONG` cycles after reset is released.
- R2: A write to the control register (address `CTRL_ADDR`, default 0) reloads the count and selects the window: 0x5A gives `T_LONG`, 0x57 gives `T_HALF`, 0x59 gives `T_QUART`, 0x53 gives `T_EIGHTH`. A restart in the middle of a window discards the remaining count.
- R3: Writes to the control register of any other value, including 0x5F, 0x00 and 0x51, leave the count unchanged. Writes to an address that is neither register leave the count unchanged.
- R4: The request is high for exactly one cycle. In that same cycle the count reloads to `T_LONG`, whatever window was selected before.
- R5: In normal mode the count advances only in cycles where `tick_32k` is 1. With no ticks, no request ever occurs.
- R6: Writing 0x5C to the test register (address `TEST_ADDR`, default 1) selects fast mode. From then on the count advances on every clock cycle, whether `tick_32k` is 0 or 1.
- R7: Writing 0x51 and then 0x54 to the test register, with no other test-register write between them, disables the watchdog until reset. After that no request occurs, even after a restart code. Control-register writes between the two bytes do not break the sequence.
- R8: A sequence that is broken does not disable the watchdog. This covers any other test-register write between 0x51 and 0x54, and a 0x54 written without a preceding 0x51. The watchdog keeps timing out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_32k | input | 1 | One-cycle enable at the 32 kHz time-base rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | 8 | Write data byte |
| wdt_rst_req | output | 1 | One-cycle processor reset request |

## Verification
Each restart code is followed by a count of cycles up to the request. This tells the four window lengths apart, and also tells a keyed reload apart from an ignored write that lets the old count run on. The time base is driven in three ways: on every cycle, every third cycle, and not at all. The cycles-to-expiry figure then shows whether the count follows the tick, and whether fast mode really ignores it. Intact, interrupted and unprimed disable sequences are each followed by a restart and a long wait. Whether a request arrives shows whether the disable state was reached.

// File: rtl/kwd_pkg.sv
// Shared definitions for the keyed watchdog: window selector type and the
// byte codes recognised on the control and test registers.
package kwd_pkg;

    typedef enum logic [1:0] {
        WIN_LONG   = 2'd0,
        WIN_HALF   = 2'd1,
        WIN_QUART  = 2'd2,
        WIN_EIGHTH = 2'd3
    } win_sel_t;

    localparam logic [7:0] CODE_LONG    = 8'h5A;
    localparam logic [7:0] CODE_HALF    = 8'h57;
    localparam logic [7:0] CODE_QUART   = 8'h59;
    localparam logic [7:0] CODE_EIGHTH  = 8'h53;

    localparam logic [7:0] KEY_FIRST    = 8'h51;
    localparam logic [7:0] KEY_SECOND   = 8'h54;
    localparam logic [7:0] KEY_FAST     = 8'h5C;

endpackage

// File: rtl/kwd_key_decode.sv
// kwd_key_decode: turns a control-register write into a restart strobe and a
// window selection. Purely combinational; assumes the caller has already
// qualified the strobe with the control-register address.
module kwd_key_decode
    import kwd_pkg::*;
(
    input  logic       ctrl_wr,
    input  logic [7:0] data,
    output logic       restart,
    output win_sel_t   sel
);

    // Match the written byte against the four restart keys.
    always_comb begin
        restart = 1'b0;
        sel     = WIN_LONG;
        if (ctrl_wr) begin
            unique case (data)
                CODE_LONG:   begin restart = 1'b1; sel = WIN_LONG;   end
                CODE_HALF:   begin restart = 1'b1; sel = WIN_HALF;   end
                CODE_QUART:  begin restart = 1'b1; sel = WIN_QUART;  end
                CODE_EIGHTH: begin restart = 1'b1; sel = WIN_EIGHTH; end
                default:     begin restart = 1'b0; sel = WIN_LONG;   end
            endcase
        end
    end

endmodule

// File: rtl/kwd_test_ctrl.sv
// kwd_test_ctrl: test-register state. Tracks the two-byte disable sequence
// and the fast-mode latch. Both outputs are sticky until rst_n.
// Assumes test_wr is already qualified with the test-register address.
module kwd_test_ctrl
    import kwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       test_wr,
    input  logic [7:0] data,
    output logic       wd_off,
    output logic       fast_mode
);

    logic primed;

    // Disable sequence: first key primes, second key (only if primed) disables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed <= 1'b0;
            wd_off <= 1'b0;
        end else if (test_wr) begin
            if (data == KEY_FIRST) begin
                primed <= 1'b1;
            end else if (data == KEY_SECOND && primed) begin
                primed <= 1'b0;
                wd_off <= 1'b1;
            end else begin
                primed <= 1'b0;
            end
        end
    end

    // Fast-mode latch: set by its key, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fast_mode <= 1'b0;
        else if (test_wr && data == KEY_FAST)
            fast_mode <= 1'b1;
    end

    // R7
    off_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_off |=> wd_off);

    // R8
    off_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_off) |-> $past(test_wr) && $past(data) == KEY_SECOND);

endmodule

// File: rtl/kwd_down_counter.sv
// kwd_down_counter: window counter. Loads the chosen window on restart,
// decrements on each advance while running, and emits a one-cycle expiry
// pulse when the last advance lands, reloading to the longest window.
// Assumes T_LONG is the largest window and all windows are at least 1.
module kwd_down_counter
    import kwd_pkg::*;
#(
    parameter int T_LONG   = 65536,
    parameter int T_HALF   = 32768,
    parameter int T_QUART  = 16384,
    parameter int T_EIGHTH = 8192
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     restart,
    input  win_sel_t sel,
    input  logic     advance,
    input  logic     run,
    output logic     expire
);

    localparam int CW = $clog2(T_LONG + 1);
    localparam logic [CW-1:0] LOAD_LONG   = CW'(T_LONG);
    localparam logic [CW-1:0] LOAD_HALF   = CW'(T_HALF);
    localparam logic [CW-1:0] LOAD_QUART  = CW'(T_QUART);
    localparam logic [CW-1:0] LOAD_EIGHTH = CW'(T_EIGHTH);
    localparam logic [CW-1:0] ONE         = CW'(1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] load_val;
    logic          step;

    // Map the selected window to its load value.
    always_comb begin
        unique case (sel)
            WIN_LONG:   load_val = LOAD_LONG;
            WIN_HALF:   load_val = LOAD_HALF;
            WIN_QUART:  load_val = LOAD_QUART;
            WIN_EIGHTH: load_val = LOAD_EIGHTH;
            default:    load_val = LOAD_LONG;
        endcase
    end

    // An advance only counts while the watchdog is running.
    always_comb step = advance && run;

    // Count down; restart wins over an advance in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= LOAD_LONG;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (restart) begin
                cnt <= load_val;
            end else if (step) begin
                if (cnt == ONE) begin
                    expire <= 1'b1;
                    cnt    <= LOAD_LONG;
                end else begin
                    cnt <= cnt - ONE;
                end
            end
        end
    end

    // R2
    reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> cnt == $past(load_val));

    // R4
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);

    // R4
    reload_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> cnt == LOAD_LONG);

    // R5
    hold_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !restart) |=> $stable(cnt));

    // R1
    never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt != '0);

endmodule

// File: rtl/kwd_timer.sv
// kwd_timer: keyed-restart watchdog top. Decodes register writes, chooses
// the count source (slow tick or every clock in fast mode) and drives the
// one-cycle processor reset request. Assumes tick_32k is a single-cycle
// enable synchronous to clk.
module kwd_timer
    import kwd_pkg::*;
#(
    parameter int          T_LONG     = 65536,
    parameter int          T_HALF     = 32768,
    parameter int          T_QUART    = 16384,
    parameter int          T_EIGHTH   = 8192,
    parameter int          ADDR_W     = 2,
    parameter int          CTRL_ADDR  = 0,
    parameter int          TEST_ADDR  = 1,
    parameter bit          ALLOW_FAST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_32k,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              wdt_rst_req
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_TEST = ADDR_W'(TEST_ADDR);

    logic     ctrl_wr;
    logic     test_wr;
    logic     restart;
    win_sel_t sel;
    logic     wd_off;
    logic     fast_mode;
    logic     advance;

    // Address qualification of the write strobe.
    always_comb begin
        ctrl_wr = wr_en && (wr_addr == A_CTRL);
        test_wr = wr_en && (wr_addr == A_TEST);
    end

    kwd_key_decode u_decode (
        .ctrl_wr (ctrl_wr),
        .data    (wr_data),
        .restart (restart),
        .sel     (sel)
    );

    kwd_test_ctrl u_test (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_wr   (test_wr),
        .data      (wr_data),
        .wd_off    (wd_off),
        .fast_mode (fast_mode)
    );

    // Count-source selection; fast mode can be compiled out.
    generate
        if (ALLOW_FAST) begin : g_fast
            always_comb advance = fast_mode ? 1'b1 : tick_32k;
        end else begin : g_slow
            always_comb advance = tick_32k;
        end
    endgenerate

    kwd_down_counter #(
        .T_LONG   (T_LONG),
        .T_HALF   (T_HALF),
        .T_QUART  (T_QUART),
        .T_EIGHTH (T_EIGHTH)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .sel     (sel),
        .advance (advance),
        .run     (!wd_off),
        .expire  (wdt_rst_req)
    );

    // R7
    silent_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_off && $past(wd_off)) |-> !wdt_rst_req);

    // R1
    quiet_in_reset_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> !wdt_rst_req);

endmodule

// File: tb/kwd_timer_test.sv
module kwd_timer_test;

    localparam int NL = 64;
    localparam int NH = 32;
    localparam int NQ = 16;
    localparam int NE = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_32k = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic       wdt_rst_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    kwd_timer #(
        .T_LONG (NL), .T_HALF (NH), .T_QUART (NQ), .T_EIGHTH (NE),
        .ADDR_W (2), .CTRL_ADDR (0), .TEST_ADDR (1), .ALLOW_FAST (1'b1)
    ) uut (
        .clk (clk), .rst_n (rst_n), .tick_32k (tick_32k),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .wdt_rst_req (wdt_rst_req)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick_32k = 1'b0; wr_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(wdt_rst_req == 1'b0, "R1 reset", int'(wdt_rst_req), 0);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        tick_32k = 1'b0;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Returns the cycle count to the request, or -1 if none within limit.
    task automatic wait_req(input int per, input int limit, output int n);
        n = -1;
        for (int i = 1; i <= limit; i++) begin
            tick_32k = (per > 0) && (i % per == 0);
            @(posedge clk);
            @(negedge clk);
            if (wdt_rst_req) begin
                n = i;
                break;
            end
        end
        tick_32k = 1'b0;
    endtask

    task automatic t_reset_state();
        int n;
        do_reset();
        wait_req(1, 3 * NL, n);
        check(n == NL, "R1 first window", n, NL);
    endtask

    task automatic t_codes();
        int n;
        do_reset(); wr(2'd0, 8'h5A); wait_req(1, 3 * NL, n);
        check(n == NL, "R2 code 5A", n, NL);
        do_reset(); wr(2'd0, 8'h57); wait_req(1, 3 * NL, n);
        check(n == NH, "R2 code 57", n, NH);
        do_reset(); wr(2'd0, 8'h59); wait_req(1, 3 * NL, n);
        check(n == NQ, "R2 code 59", n, NQ);
        do_reset(); wr(2'd0, 8'h53); wait_req(1, 3 * NL, n);
        check(n == NE, "R2 code 53", n, NE);
        // restart mid-window
        do_reset(); wr(2'd0, 8'h53); wait_req(1, 4, n);
        check(n == -1, "R2 early", n, -1);
        wr(2'd0, 8'h57); wait_req(1, 3 * NL, n);
        check(n == NH, "R2 mid restart", n, NH);
    endtask

    task automatic t_ignored();
        int n;
        do_reset(); wr(2'd0, 8'h53); wait_req(1, 4, n);
        check(n == -1, "R3 early", n, -1);
        wr(2'd0, 8'h5F);
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h51);
        wr(2'd2, 8'h5A);
        wait_req(1, 3 * NL, n);
        check(n == NE - 4, "R3 ignored writes", n, NE - 4);
    endtask

    task automatic t_expiry_reload();
        int n;
        do_reset(); wr(2'd0, 8'h53); wait_req(1, 3 * NL, n);
        check(n == NE, "R4 first expiry", n, NE);
        wait_req(1, 3 * NL, n);
        check(n == NL, "R4 reload long and single pulse", n, NL);
    endtask

    task automatic t_tick_gating();
        int n;
        do_reset(); wr(2'd0, 8'h59); wait_req(3, 10 * NL, n);
        check(n == 3 * NQ, "R5 tick every third", n, 3 * NQ);
        do_reset(); wr(2'd0, 8'h53); wait_req(0, 4 * NL, n);
        check(n == -1, "R5 no tick", n, -1);
    endtask

    task automatic t_fast_mode();
        int n;
        do_reset(); wr(2'd1, 8'h5C); wr(2'd0, 8'h59); wait_req(0, 3 * NL, n);
        check(n == NQ, "R6 fast without tick", n, NQ);
        wr(2'd0, 8'h53); wait_req(5, 3 * NL, n);
        check(n == NE, "R6 fast ignores tick", n, NE);
    endtask

    task automatic t_disable();
        int n;
        do_reset(); wr(2'd1, 8'h51); wr(2'd0, 8'h5A); wr(2'd1, 8'h54);
        wr(2'd0, 8'h53); wait_req(1, 4 * NL, n);
        check(n == -1, "R7 disabled", n, -1);
    endtask

    task automatic t_broken();
        int n;
        do_reset(); wr(2'd1, 8'h51); wr(2'd1, 8'h00); wr(2'd1, 8'h54);
        wr(2'd0, 8'h53); wait_req(1, 4 * NL, n);
        check(n == NE, "R8 interrupted sequence", n, NE);
        do_reset(); wr(2'd1, 8'h54);
        wr(2'd0, 8'h53); wait_req(1, 4 * NL, n);
        check(n == NE, "R8 second byte alone", n, NE);
    endtask

    initial begin
        t_reset_state();
        t_codes();
        t_ignored();
        t_expiry_reload();
        t_tick_gating();
        t_fast_mode();
        t_disable();
        t_broken();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule